// File: doc/BRIEF.md
# Byte Permute Lookup Unit

The unit performs a vector byte permutation against a small bank of 64-bit table registers. A request carries three operands: a 64-bit index vector, a 64-bit fallback vector and a descriptor. The descriptor names the first table register and says how many consecutive registers (one to four) make up the table. Each of the eight index bytes is treated on its own. If the index falls inside the table, the matching byte of the table is fetched. If it does not, the byte in the same lane of the fallback vector is used. The chosen byte always lands in the lane its index came from.

The table registers are loaded through a plain synchronous write port. Lookups use a valid/ready handshake and produce a registered result one cycle after acceptance. A full output register that is not drained stalls new requests. Together, the two operand vectors and the descriptor let software build multi-register lookups and chain partial lookups through the fallback vector.

Top module: `byte_permute_lut`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rsp_valid` is 0 and `req_ready` is 1.
- R2: The table length comes from `req_desc[1:0]` as L. An index byte is in range exactly when its value is below (L+1)*8. Values from 0x20 to 0xFF are never in range.
- R3: The first table register comes from `req_desc[6:2]` as B. An in-range index i reads register B + (i>>3) and takes its byte i&7, which is bits (i&7)*8+7 down to (i&7)*8.
- R4: When an index byte is out of range, its result lane copies the byte in the same lane of `req_default`.
- R5: The index byte at bits 8k+7..8k decides only result bits 8k+7..8k, for every lane k from 0 to 7, and each lane is decided independently of the others.
- R6: The register number B + (i>>3) wraps modulo 32, so a table that starts near register 31 continues at register 0.
- R7: A request accepted at a clock edge (`req_valid` and `req_ready` both high) makes `rsp_valid` high after that edge, with the lookup result on `rsp_data`.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_valid` and `rsp_data` hold their values.
- R9: When `wr_en` is high at a clock edge, `wr_data` is stored in register `wr_addr`. A lookup accepted at that same edge sees the previous contents. Lookups accepted at later edges see the new value.
- R10: When `rsp_valid` and `rsp_ready` are both high and no request is accepted, `rsp_valid` is low after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table register write enable |
| wr_addr | input | 5 | Table register number to write |
| wr_data | input | 64 | Table register write value |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_desc | input | 7 | [1:0] length minus one, [6:2] first register |
| req_index | input | 64 | Eight index bytes |
| req_default | input | 64 | Fallback bytes for out-of-range lanes |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 64 | Lookup result |

## Verification
The table is filled so that every byte of every register holds a distinct value. Any fetched byte therefore reveals which register and which byte position it came from. The lookup is swept over all four lengths and over bases that include 29 and 31. A rotating index pattern puts in-range and out-of-range values in every lane, which separates the limit decision, the register offset, the byte selection and lane placement. Further patterns use indices with high bits set, an all-out-of-range vector, and a write to the register being read in the same cycle. These distinguish the upper-bit check, fallback routing and the read-before-write ordering. A stalled output separates hold behaviour from draining.

// File: rtl/bpl_pkg.sv
package bpl_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bpl_regbank.sv
// Table register bank: one synchronous write port, RD_PORTS asynchronous reads.
module bpl_regbank #(
  parameter int NUM_REGS = 32,
  parameter int WORD_W   = 64,
  parameter int RD_PORTS = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                              clk,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [WORD_W-1:0]                 wr_data,
  input  logic [RD_PORTS-1:0][ADDR_W-1:0]   rd_addr,
  output logic [RD_PORTS-1:0][WORD_W-1:0]   rd_data
);
  logic [WORD_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_data[p] = mem[rd_addr[p]];
  end
endmodule

// File: rtl/bpl_lane.sv
// One result lane: range decision, register address, byte pick or fallback.
module bpl_lane
  import bpl_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LEN_W  = 2,
  parameter int LANES  = 8
) (
  input  byte_t                          idx,
  input  logic [LEN_W-1:0]               len,
  input  logic [ADDR_W-1:0]              base,
  input  byte_t                          dflt,
  input  logic [LANES-1:0][BYTE_W-1:0]   word,
  output logic [ADDR_W-1:0]              rd_addr,
  output byte_t                          result
);
  localparam int SEL_W = $clog2(LANES);
  localparam int TOP   = SEL_W + LEN_W;
  localparam int HI_W  = BYTE_W - TOP;

  logic [SEL_W-1:0] sel;
  logic [LEN_W-1:0] ofs;
  logic             hi_clear;
  logic             in_range;

  assign sel = idx[SEL_W-1:0];
  assign ofs = idx[TOP-1:SEL_W];

  if (HI_W > 0) begin : g_hi
    assign hi_clear = (idx[BYTE_W-1:TOP] == '0);
  end else begin : g_nohi
    assign hi_clear = 1'b1;
  end

  assign in_range = hi_clear && (ofs <= len);
  assign rd_addr  = base + ADDR_W'(ofs);
  assign result   = in_range ? word[sel] : dflt;
endmodule

// File: rtl/byte_permute_lut.sv
module byte_permute_lut
  import bpl_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int LANES    = 8,
  parameter int LEN_W    = 2,
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int WORD_W  = LANES * BYTE_W,
  localparam int DESC_W  = LEN_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DESC_W-1:0] req_desc,
  input  logic [WORD_W-1:0] req_index,
  input  logic [WORD_W-1:0] req_default,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data
);
  logic [LEN_W-1:0]                  len;
  logic [ADDR_W-1:0]                 base;
  logic [LANES-1:0][ADDR_W-1:0]      rd_addr;
  logic [LANES-1:0][WORD_W-1:0]      rd_data;
  logic [LANES-1:0][BYTE_W-1:0]      idx_b;
  logic [LANES-1:0][BYTE_W-1:0]      dflt_b;
  logic [LANES-1:0][BYTE_W-1:0]      res_b;
  logic                              accept;

  assign len    = req_desc[LEN_W-1:0];
  assign base   = req_desc[DESC_W-1:LEN_W];
  assign idx_b  = req_index;
  assign dflt_b = req_default;

  bpl_regbank #(
    .NUM_REGS (NUM_REGS),
    .WORD_W   (WORD_W),
    .RD_PORTS (LANES)
  ) bank_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bpl_lane #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .LANES  (LANES)
    ) lane_i (
      .idx     (idx_b[k]),
      .len     (len),
      .base    (base),
      .dflt    (dflt_b[k]),
      .word    (rd_data[k]),
      .rd_addr (rd_addr[k]),
      .result  (res_b[k])
    );
  end

  // Output stage: one register, refilled when empty or being drained.
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= res_b;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bpl_checker.sv
module bpl_checker #(
  parameter int LANES  = 8,
  parameter int LEN_W  = 2,
  localparam int WORD_W = LANES * 8,
  localparam int MAX_LIMIT = (1 << LEN_W) * LANES
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [WORD_W-1:0] req_index,
  input logic [WORD_W-1:0] req_default,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_data
);
  logic rst_q;
  logic all_out;

  always_comb begin
    all_out = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      if (int'(req_index[8*k +: 8]) < MAX_LIMIT) all_out = 1'b0;
    end
  end

  always_ff @(posedge clk) rst_q <= rst;

  // R1: output empty in the cycle after reset
  always_ff @(posedge clk) begin
    if (rst_q) a_r1_idle_after_reset: assert (!rsp_valid);
  end

  a_r7_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r10_drain_empties: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ready && !(req_valid && req_ready)) |=> !rsp_valid);

  a_r4_all_fallback: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && all_out) |=> (rsp_data == $past(req_default)));
endmodule

bind byte_permute_lut bpl_checker #(
  .LANES (LANES),
  .LEN_W (LEN_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_index   (req_index),
  .req_default (req_default),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data)
);

// File: tb/byte_permute_lut_tb_top.sv
module byte_permute_lut_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_desc = '0;
  logic [63:0] req_index = '0;
  logic [63:0] req_default = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_data;

  int tests = 0;
  int fails = 0;
  logic [63:0] shadow [32];

  always #2.5 clk = ~clk;

  byte_permute_lut dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_desc(req_desc),
    .req_index(req_index), .req_default(req_default), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [6:0] d, input logic [63:0] ix, input logic [63:0] df);
    logic [63:0] r = '0;
    int len = int'(d[1:0]);
    int base = int'(d[6:2]);
    for (int k = 0; k < 8; k++) begin
      int i = int'(ix[8*k +: 8]);
      if (i < (len + 1) * 8) begin
        int rg = (base + i / 8) % 32;
        r[8*k +: 8] = shadow[rg][8*(i%8) +: 8];
      end else begin
        r[8*k +: 8] = df[8*k +: 8];
      end
    end
    return r;
  endfunction

  task automatic write_reg(input int a, input logic [63:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    shadow[a] = v;
  endtask

  task automatic lookup(input logic [6:0] d, input logic [63:0] ix, input logic [63:0] df, input string req);
    logic [63:0] exp;
    exp = model(d, ix, df);
    @(negedge clk);
    req_valid = 1'b1; req_desc = d; req_index = ix; req_default = df;
    chk(req_ready == 1'b1, "R7 ready before request", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R7 valid after accept", 64'(rsp_valid), 64'd1);
    chk(rsp_data == exp, req, rsp_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] oldv, newv, first;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 valid during reset", 64'(rsp_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 valid after reset", 64'(rsp_valid), 64'd0);
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);

    // Every table byte distinct: value encodes register and byte position
    for (int r = 0; r < 32; r++) begin
      logic [63:0] v;
      for (int b = 0; b < 8; b++) v[8*b +: 8] = 8'(r * 8 + b) ^ 8'h5A;
      write_reg(r, v);
    end

    // Sweep lengths, bases (incl. wrap), rotating indices over 0..39
    for (int len = 0; len < 4; len++) begin
      for (int bi = 0; bi < 4; bi++) begin
        int base = (bi == 0) ? 0 : (bi == 1) ? 5 : (bi == 2) ? 29 : 31;
        for (int s = 0; s < 40; s++) begin
          logic [63:0] ix;
          for (int k = 0; k < 8; k++) ix[8*k +: 8] = 8'((s * 3 + k * 7) % 40);
          lookup({5'(base), 2'(len)}, ix, 64'hD0D1_D2D3_D4D5_D6D7 ^ 64'(s),
                 (base >= 29) ? "R2,R3,R4,R5,R6 sweep wrap" : "R2,R3,R4,R5 sweep");
        end
      end
    end

    // Upper index bits set are always out of range (R2)
    lookup({5'd3, 2'd3}, 64'hFF80_2120_1F18_0800, 64'h1122_3344_5566_7788, "R2 high bits");
    // Limit boundary for each length
    for (int len = 0; len < 4; len++) begin
      logic [63:0] ix;
      for (int k = 0; k < 8; k++) ix[8*k +: 8] = 8'((len + 1) * 8 - 1 + (k % 2));
      lookup({5'd10, 2'(len)}, ix, 64'hA0A1_A2A3_A4A5_A6A7, "R2,R4 limit edge");
    end
    // All lanes out of range: result equals fallback (R4)
    lookup({5'd0, 2'd0}, 64'h0809_0A0B_0C0D_0E0F, 64'hCAFE_F00D_1234_5678, "R4 all fallback");
    // Lane placement: identity bytes for register 2 (R5)
    lookup({5'd2, 2'd0}, 64'h0001_0203_0405_0607, 64'h0, "R5 lane order");
    chk(rsp_data == {shadow[2][7:0], shadow[2][15:8], shadow[2][23:16], shadow[2][31:24],
                     shadow[2][39:32], shadow[2][47:40], shadow[2][55:48], shadow[2][63:56]},
        "R5 reversed bytes", rsp_data, model({5'd2, 2'd0}, 64'h0001_0203_0405_0607, 64'h0));

    // Write and lookup at the same edge (R9)
    oldv = shadow[7];
    newv = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd7; wr_data = newv;
    req_valid = 1'b1; req_desc = {5'd7, 2'd0}; req_index = 64'h0706_0504_0302_0100; req_default = '0;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk(rsp_data == oldv, "R9 same-edge read sees old", rsp_data, oldv);
    shadow[7] = newv;
    lookup({5'd7, 2'd0}, 64'h0706_0504_0302_0100, 64'h0, "R9 later read sees new");
    chk(rsp_data == newv, "R9 new value", rsp_data, newv);

    // Backpressure (R8) then drain (R10)
    first = model({5'd1, 2'd1}, 64'h0F0E_0D0C_0B0A_0908, 64'h0);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_desc = {5'd1, 2'd1}; req_index = 64'h0F0E_0D0C_0B0A_0908; req_default = '0;
    @(negedge clk);
    req_index = 64'h0;
    for (int c = 0; c < 3; c++) begin
      chk(req_ready == 1'b0, "R8 ready low when stalled", 64'(req_ready), 64'd0);
      chk(rsp_valid == 1'b1, "R8 valid held", 64'(rsp_valid), 64'd1);
      chk(rsp_data == first, "R8 data held", rsp_data, first);
      @(negedge clk);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 drained", 64'(rsp_valid), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule